// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block decodes the bus write cycles that a host issues to a 16-bit parallel NOR flash with a word-addressed command interface. It follows the multi-write unlock protocol, chooses what a read returns (stored array data, identification words, or the query table), writes programmed words into a small on-chip word store, and hands chip or sector erase requests to an external erase engine as a one-cycle strobe with the target attached.

Reads are combinational from `rd_addr`. Writes are sampled on the rising clock edge when `wr_en` is high. Command addresses are decoded on the low 11 word-address bits. Command bytes are decoded on the low 8 data bits.

The sequencer states are these. IDLE waits for the first key or a direct command. KEY1 means 0xAA has been seen at 0x555. KEY2 means 0x55 has also been seen at 0x2AA. PROG waits for the data word of a program. ERS1, ERS2 and ERS3 follow the erase prefix and wait for the second key pair and then the erase code. BYP is the unlock-bypass idle state. BPROG waits for the data word of a bypass program.

The transitions are these:
- IDLE to KEY1 on the first key. KEY1 to KEY2 on the second key.
- KEY2 to IDLE on the identify command (0x90). KEY2 to PROG on 0xA0. KEY2 to ERS1 on 0x80. KEY2 to BYP on 0x20.
- PROG to IDLE on the data word.
- ERS1 to ERS2 to ERS3 on the repeated key pair. ERS3 to IDLE on the erase code.
- BYP to BPROG on 0xA0. BPROG to BYP on the data word. BYP to IDLE on 0x00.
- From IDLE, KEY1, KEY2, ERS1, ERS2 and ERS3, 0xF0 exits to IDLE. Any other mismatch in these states aborts to IDLE.

The read modes are ARRAY, IDENT and QUERY. A separate nest flag records that QUERY was entered from IDENT.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the read mode is ARRAY, every word of the store reads 0xFFFF, and erase_req is low.
- R2: The key pair (0xAA at 0x555, then 0x55 at 0x2AA) followed by 0x90 at 0x555 selects IDENT. In IDENT, read word 0 returns 0x00BF, word 1 returns 0x236D, and other words return 0x0000.
- R3: From IDLE, 0x98 written at 0x055 selects QUERY. In QUERY, read words 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059, and other words return 0x0000.
- R4: 0xF0 at any address, written in any state other than PROG, BPROG or BYP, returns the sequencer to IDLE and the read mode to ARRAY.
- R5: If QUERY was entered while in IDENT, the first 0xF0 returns the read mode to IDENT. A further 0xF0 returns it to ARRAY.
- R6: The key pair, then 0xA0 at 0x555, then a data write programs that word. The stored value becomes the old value AND the new value, so only bits can be cleared.
- R7: The key pair, 0x80 at 0x555, the key pair again, then 0x10 at 0x555 raises erase_req with erase_chip=1. If the last write is instead 0x30 at any address, erase_req rises with erase_chip=0 and erase_sector equal to write address bits [AW-1:SECT_SHIFT].
- R8: Command addresses are matched on word-address bits [10:0] only, so 0x5555 and 0x2AAA act as 0x555 and 0x2AA.
- R9: A write that does not match the next expected cycle of a sequence returns the sequencer to IDLE. It programs nothing, requests no erase, and leaves the read mode unchanged.
- R10: The key pair plus 0x20 at 0x555 enters BYP. In BYP, 0xA0 at any address followed by a data write programs a word with no key pair. Other writes in BYP have no effect.
- R11: 0x00 written in BYP leaves bypass. After that, a bare 0xA0 followed by a data write programs nothing.
- R12: Command bytes are compared on data bits [7:0] only. Bits [15:8] of a command write are ignored.
- R13: erase_req is a single-cycle pulse. It is high in the cycle after the clock edge that samples the final erase write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, sampled on the rising edge |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 16 | Write data or command byte in bits [7:0] |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | 16 | Read data for the current read mode |
| erase_req | output | 1 | One-cycle erase request strobe |
| erase_chip | output | 1 | 1 = whole-chip erase, 0 = sector erase |
| erase_sector | output | AW-SECT_SHIFT | Sector index for a sector erase |

## Verification
A wrong sequencer state shows at the ports in one of three ways:
- a read on the next cycle returns identification or query words where array data was expected, or the reverse;
- a word that should have stayed 0xFFFF reads back with bits cleared;
- an erase strobe is missing, or appears with the wrong target, in the cycle after the final write.

Because reads are combinational, every mode or store error is visible one cycle after the write that caused it. A lost nest flag appears only after the following 0xF0, and the bench reads straight after it. Bypass mistakes are exposed by a word-by-word sweep of the whole store against a model that ANDs each value written.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    typedef enum logic [3:0] {
        SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PROG, SQ_ERS1, SQ_ERS2, SQ_ERS3, SQ_BYP, SQ_BPROG
    } seq_state_t;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_QUERY} rd_mode_t;

    localparam int DEC_AW = 11;
    localparam logic [DEC_AW-1:0] A_KEY1  = 11'h555;
    localparam logic [DEC_AW-1:0] A_KEY2  = 11'h2AA;
    localparam logic [DEC_AW-1:0] A_QUERY = 11'h055;

    localparam logic [7:0] CB_KEY1  = 8'hAA;
    localparam logic [7:0] CB_KEY2  = 8'h55;
    localparam logic [7:0] CB_IDENT = 8'h90;
    localparam logic [7:0] CB_PROG  = 8'hA0;
    localparam logic [7:0] CB_ERS   = 8'h80;
    localparam logic [7:0] CB_CHIP  = 8'h10;
    localparam logic [7:0] CB_SECT  = 8'h30;
    localparam logic [7:0] CB_BYP   = 8'h20;
    localparam logic [7:0] CB_BYPX  = 8'h00;
    localparam logic [7:0] CB_EXIT  = 8'hF0;
    localparam logic [7:0] CB_QUERY = 8'h98;

    localparam logic [15:0] ID_MFR = 16'h00BF;
    localparam logic [15:0] ID_DEV = 16'h236D;
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int AW         = 20,
    parameter int SECT_SHIFT = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [15:0]            wr_data,
    output rd_mode_t               rd_mode,
    output logic                   nest_q,
    output logic                   prog_we,
    output logic                   erase_req,
    output logic                   erase_chip,
    output logic [AW-SECT_SHIFT-1:0] erase_sector
);
    localparam int SW = AW - SECT_SHIFT;

    seq_state_t state_q, state_d;
    rd_mode_t   mode_d;
    logic       nest_d;
    logic       ers_fire, ers_chip_d, go_exit;
    logic [7:0] cb;
    logic [DEC_AW-1:0] ca;
    logic at_k1, at_k2, at_q;

    assign cb    = wr_data[7:0];
    assign ca    = wr_addr[DEC_AW-1:0];
    assign at_k1 = (ca == A_KEY1);
    assign at_k2 = (ca == A_KEY2);
    assign at_q  = (ca == A_QUERY);

    always_comb begin
        state_d    = state_q;
        mode_d     = rd_mode;
        nest_d     = nest_q;
        ers_fire   = 1'b0;
        ers_chip_d = 1'b0;
        prog_we    = 1'b0;
        go_exit    = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (cb == CB_KEY1 && at_k1) state_d = SQ_KEY1;
                    else if (cb == CB_QUERY && at_q && rd_mode != RM_QUERY) begin
                        mode_d = RM_QUERY;
                        nest_d = (rd_mode == RM_IDENT);
                    end
                end
                SQ_KEY1: begin
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (cb == CB_KEY2 && at_k2) state_d = SQ_KEY2;
                    else state_d = SQ_IDLE;
                end
                SQ_KEY2: begin
                    state_d = SQ_IDLE;
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (at_k1) begin
                        if (cb == CB_IDENT) begin
                            mode_d = RM_IDENT;
                            nest_d = 1'b0;
                        end else if (cb == CB_PROG) state_d = SQ_PROG;
                        else if (cb == CB_ERS)  state_d = SQ_ERS1;
                        else if (cb == CB_BYP)  state_d = SQ_BYP;
                    end
                end
                SQ_PROG: begin
                    prog_we = 1'b1;
                    state_d = SQ_IDLE;
                end
                SQ_ERS1: begin
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (cb == CB_KEY1 && at_k1) state_d = SQ_ERS2;
                    else state_d = SQ_IDLE;
                end
                SQ_ERS2: begin
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (cb == CB_KEY2 && at_k2) state_d = SQ_ERS3;
                    else state_d = SQ_IDLE;
                end
                SQ_ERS3: begin
                    state_d = SQ_IDLE;
                    if (cb == CB_EXIT) go_exit = 1'b1;
                    else if (cb == CB_CHIP && at_k1) begin
                        ers_fire   = 1'b1;
                        ers_chip_d = 1'b1;
                    end else if (cb == CB_SECT) ers_fire = 1'b1;
                end
                SQ_BYP: begin
                    if (cb == CB_PROG) state_d = SQ_BPROG;
                    else if (cb == CB_BYPX) state_d = SQ_IDLE;
                end
                SQ_BPROG: begin
                    prog_we = 1'b1;
                    state_d = SQ_BYP;
                end
                default: state_d = SQ_IDLE;
            endcase
            if (go_exit) begin
                state_d = SQ_IDLE;
                mode_d  = (rd_mode == RM_QUERY && nest_q) ? RM_IDENT : RM_ARRAY;
                nest_d  = 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            rd_mode <= RM_ARRAY;
            nest_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_mode <= mode_d;
            nest_q  <= nest_d;
        end
    end

    // registered erase hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req    <= 1'b0;
            erase_chip   <= 1'b0;
            erase_sector <= '0;
        end else begin
            erase_req <= ers_fire;
            if (ers_fire) begin
                erase_chip   <= ers_chip_d;
                erase_sector <= ers_chip_d ? '0 : wr_addr[AW-1:AW-SW];
            end
        end
    end
endmodule

// File: rtl/nor_word_store.sv
module nor_word_store #(
    parameter int MEM_AW = 6,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << MEM_AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_cmd_pkg::*;
(
    input  rd_mode_t          mode,
    input  logic [DEC_AW-1:0] idx,
    input  logic [15:0]       array_data,
    output logic [15:0]       rd_data
);
    always_comb begin
        rd_data = 16'h0000;
        unique case (mode)
            RM_ARRAY: rd_data = array_data;
            RM_IDENT: begin
                if (idx == 11'h000) rd_data = ID_MFR;
                else if (idx == 11'h001) rd_data = ID_DEV;
            end
            RM_QUERY: begin
                if (idx == 11'h010) rd_data = 16'h0051;
                else if (idx == 11'h011) rd_data = 16'h0052;
                else if (idx == 11'h012) rd_data = 16'h0059;
            end
            default: rd_data = 16'h0000;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int AW         = 20,
    parameter int SECT_SHIFT = 15,
    parameter int MEM_AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [15:0]              wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [15:0]              rd_data,
    output logic                     erase_req,
    output logic                     erase_chip,
    output logic [AW-SECT_SHIFT-1:0] erase_sector
);
    rd_mode_t    rd_mode;
    logic        nest_q;
    logic        prog_we;
    logic [15:0] array_data;

    nor_cmd_fsm #(.AW(AW), .SECT_SHIFT(SECT_SHIFT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_mode(rd_mode), .nest_q(nest_q), .prog_we(prog_we),
        .erase_req(erase_req), .erase_chip(erase_chip), .erase_sector(erase_sector)
    );

    nor_word_store #(.MEM_AW(MEM_AW), .DW(16)) u_store (
        .clk(clk), .rst_n(rst_n), .we(prog_we), .waddr(wr_addr[MEM_AW-1:0]),
        .wdata(wr_data), .raddr(rd_addr[MEM_AW-1:0]), .rdata(array_data)
    );

    nor_read_mux u_rmux (
        .mode(rd_mode), .idx(rd_addr[DEC_AW-1:0]), .array_data(array_data), .rd_data(rd_data)
    );
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_cmd_pkg::*;
#(
    parameter int AW = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [15:0] rd_data,
    input logic        erase_req,
    input rd_mode_t    rd_mode,
    input logic        nest_q
);
    a_r13_erase_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    a_r7_erase_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(wr_en) && ($past(wr_data[7:0]) == 8'h10 || $past(wr_data[7:0]) == 8'h30)));

    a_r2_ident_word0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == RM_IDENT && rd_addr[10:0] == 11'h000) |-> rd_data == 16'h00BF);

    a_r3_query_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == RM_QUERY && rd_addr[10:0] == 11'h010) |-> rd_data == 16'h0051);

    a_r5_nest_in_query: assert property (@(posedge clk) disable iff (!rst_n)
        nest_q |-> rd_mode == RM_QUERY);

    a_r9_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_mode));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .erase_req(erase_req), .rd_mode(rd_mode), .nest_q(nest_q)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
    localparam int AW = 20;
    localparam int SS = 15;
    localparam int MA = 6;
    localparam int DEPTH = 1 << MA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic erase_req, erase_chip;
    logic [AW-SS-1:0] erase_sector;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [DEPTH];

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .SECT_SHIFT(SS), .MEM_AW(MA)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .erase_req(erase_req),
        .erase_chip(erase_chip), .erase_sector(erase_sector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(tag, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic keys();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0055);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
        keys();
        wr(20'h00555, 16'h00A0);
        wr(a, d);
        model[a[MA-1:0]] = model[a[MA-1:0]] & d;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 word0", 20'h0, 16'hFFFF);
        rd_chk("R1 word63", 20'h3F, 16'hFFFF);
        check("R1 erase_req", {31'h0, erase_req}, 32'h0);

        // R2 identify
        keys(); wr(20'h00555, 16'h0090);
        rd_chk("R2 mfr", 20'h0, 16'h00BF);
        rd_chk("R2 dev", 20'h1, 16'h236D);
        rd_chk("R2 other", 20'h2, 16'h0000);
        // R4 exit at arbitrary address
        wr(20'h01234, 16'h00F0);
        rd_chk("R4 exit ident", 20'h0, 16'hFFFF);

        // R3 query from array
        wr(20'h00055, 16'h0098);
        rd_chk("R3 Q", 20'h10, 16'h0051);
        rd_chk("R3 R", 20'h11, 16'h0052);
        rd_chk("R3 Y", 20'h12, 16'h0059);
        rd_chk("R3 other", 20'h0, 16'h0000);
        wr(20'h00000, 16'h00F0);
        rd_chk("R4 exit query", 20'h0, 16'hFFFF);

        // R5 nesting
        keys(); wr(20'h00555, 16'h0090);
        wr(20'h00055, 16'h0098);
        rd_chk("R5 in query", 20'h10, 16'h0051);
        wr(20'h00000, 16'h00F0);
        rd_chk("R5 back to ident", 20'h0, 16'h00BF);
        wr(20'h00000, 16'h00F0);
        rd_chk("R5 back to array", 20'h0, 16'hFFFF);

        // R6 program clears bits only
        prog(20'h3, 16'h0055);
        rd_chk("R6 first", 20'h3, 16'h0055);
        prog(20'h3, 16'h00A5);
        rd_chk("R6 and", 20'h3, 16'h0005);

        // R8 high address bits ignored
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0090);
        rd_chk("R8 alias ident", 20'h0, 16'h00BF);
        wr(20'h0, 16'h00F0);

        // R12 upper data byte ignored
        wr(20'h00555, 16'h12AA); wr(20'h002AA, 16'hFF55); wr(20'h00555, 16'h3490);
        rd_chk("R12 ident", 20'h1, 16'h236D);
        wr(20'h0, 16'h77F0);
        rd_chk("R12 exit", 20'h0, 16'hFFFF);

        // R9 aborted program
        wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055);
        wr(20'h00555, 16'h00A0); wr(20'h00004, 16'h0000);
        rd_chk("R9 no program", 20'h4, 16'hFFFF);
        // R9 aborted erase
        keys(); wr(20'h00555, 16'h0080);
        wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055);
        wr(20'h08000, 16'h0030);
        check("R9 no erase", {31'h0, erase_req}, 32'h0);
        rd_chk("R9 mode kept", 20'h3, 16'h0005);

        // R7 chip erase, R13 pulse width
        keys(); wr(20'h00555, 16'h0080); keys(); wr(20'h00555, 16'h0010);
        check("R7 chip req", {31'h0, erase_req}, 32'h1);
        check("R7 chip flag", {31'h0, erase_chip}, 32'h1);
        @(negedge clk);
        check("R13 pulse drop", {31'h0, erase_req}, 32'h0);

        // R7 sector sweep
        for (int s = 0; s < (1 << (AW - SS)); s++) begin
            logic [AW-1:0] a;
            a = AW'((s << SS) | ((s * 7) & 32'h7FFF));
            keys(); wr(20'h00555, 16'h0080); keys(); wr(a, 16'h0030);
            check("R7 sector req", {31'h0, erase_req}, 32'h1);
            check("R7 sector chip", {31'h0, erase_chip}, 32'h0);
            check("R7 sector index", 32'(erase_sector), 32'(s));
        end

        // R10 bypass sweep
        keys(); wr(20'h00555, 16'h0020);
        wr(20'h00007, 16'h1234);
        rd_chk("R10 ignored write", 20'h7, 16'hFFFF);
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < DEPTH; i++) begin
                logic [15:0] d;
                d = (pass == 0) ? 16'((i * 16'h0101) ^ 16'h5A3C) : 16'(~(i * 16'h0F13));
                wr(AW'((i * 20'h123) & 20'hFFFFF), 16'h00A0);
                wr(AW'(i), d);
                model[i] = model[i] & d;
            end
            for (int i = 0; i < DEPTH; i++) rd_chk("R10 sweep", AW'(i), model[i]);
        end

        // R11 leave bypass, bare program ignored
        wr(20'h00000, 16'h0000);
        wr(20'h00009, 16'h00A0);
        wr(20'h00009, 16'h0000);
        rd_chk("R11 bare program ignored", 20'h9, model[9]);
        check("R11 word nonzero", {31'h0, (model[9] != 16'h0)}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule